// File: doc/BRIEF.md
# Sync-Locked Bitmap Pixel Scanout

This block holds a small one-bit-per-pixel picture and sends it out as a serial bit stream, one pixel per pixel-clock period. The stream is paced by external video timing: line sync pulses arrive at about 15 kHz and field sync at about 50 Hz. A pixel rate of 4 to 6 MHz comes from an internal programmable divider of the system clock. All addressing is derived from those external edges. A row counter steps on every rising edge of the sync input. A column counter steps on every pixel tick that falls while sync is high. An asynchronous active-low reset line returns both counters to the top-left pixel.

Pixels are read from the bitmap at the current column and row and registered onto the serial output. A gated pixel clock is sent out beside the data, and its rising edge coincides with each new bit. That clock runs only while the sync level is high. A plain synchronous write port loads the bitmap. The sync and reset lines are asynchronous and are synchronized inside the block.

Top module: `sync_scanout`

## Requirements
- R1: After system reset `pix_out` and `pix_clk_out` are 0, both counters are 0 and every bitmap bit reads 0.
- R2: `sync_in` and `scan_rst_n` pass through a two-flop synchronizer plus an edge register. A change on `sync_in` driven before clock edge E0 affects the block no earlier than the clock after edge E2, so `pix_clk_out` is still 0 after E2 when a line starts.
- R3: The row counter increments once per rising edge of the synchronized sync level and wraps from ROWS-1 to 0.
- R4: The column counter increments on each pixel tick that occurs while the synchronized sync level is high, wraps from COLS-1 to 0, and holds while sync is low. It does not reset at the start of a line.
- R5: On each qualifying pixel tick, `pix_out` takes the bitmap bit at the current column and row. It changes on the clock edge that ends the tick cycle, and it holds its value at all other times.
- R6: A falling edge on `scan_rst_n` clears both counters on the next clock. The counters stay at 0 while `scan_rst_n` remains low, and this clear takes priority over any increment.
- R7: `pix_clk_out` rises only on a qualifying pixel tick, on the same edge that updates `pix_out`. It has a 50% duty cycle with a period of 2*max(`div_val`,1) system clocks, and it is forced low while the synchronized sync level is low.
- R8: A `div_val` of 0 behaves exactly like 1, giving a pixel clock period of 2 system clocks.
- R9: When `wr_en` is high at a clock edge, the bitmap bit at column `wr_col` (0..COLS-1) and row `wr_row` (0..ROWS-1) takes `wr_bit`. A pixel read at that same edge from that location outputs the previous contents.
- R10: The bitmap size is set by parameters COLS (default 10) and ROWS (default 5). All COLS*ROWS locations are reachable by scanout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sync_in | input | 1 | Asynchronous sync level; rising edge steps the row, high level enables pixels |
| scan_rst_n | input | 1 | Asynchronous active-low counter reset; falling edge clears column and row |
| div_val | input | DIV_W | Half-period of the pixel clock in system clocks (0 treated as 1) |
| wr_en | input | 1 | Bitmap write strobe |
| wr_col | input | $clog2(COLS) | Bitmap write column |
| wr_row | input | $clog2(ROWS) | Bitmap write row |
| wr_bit | input | 1 | Bitmap write data |
| pix_out | output | 1 | Registered serial pixel bit |
| pix_clk_out | output | 1 | Gated pixel clock, high only during active sync |

## Verification
The assertions assume that `sync_in` and `scan_rst_n` hold each level for at least three system clocks. Under that assumption every synchronized edge appears as a single-cycle pulse, and the counter and output checks can trace each change back to one pulse or one pixel tick. They also assume that `div_val` changes only while sync is low, so the 50% clock shape is never disturbed mid-line. The stimulus holds every sync and reset level for many clocks and changes `div_val` only between lines. It loads the bitmap only while sync is low, except for one deliberate same-edge write that is aligned to a known pixel tick.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // pixel-clock phase events from the divider
    typedef struct packed {
        logic rise;
        logic fall;
    } tick_t;

endpackage

// File: rtl/scan_sync_edge.sv
module scan_sync_edge #(
    parameter bit IDLE      = 1'b0,
    parameter bit RISE_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl_o,
    output logic edge_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } chain_t;

    chain_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_in;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: IDLE, s2: IDLE, s3: IDLE};
        else        q <= d;
    end

    assign lvl_o = q.s3;

    generate
        if (RISE_EDGE) begin : g_rise
            assign edge_o = q.s2 & ~q.s3;
        end else begin : g_fall
            assign edge_o = ~q.s2 & q.s3;
        end
    endgenerate

endmodule

// File: rtl/scan_pix_div.sv
module scan_pix_div
    import scan_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output tick_t            tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } div_t;

    div_t             d, q;
    logic [DIV_W-1:0] limit;
    logic             wrap;

    always_comb begin
        limit     = (div_val == '0) ? '0 : div_val - 1'b1;
        wrap      = (q.cnt >= limit);
        d         = q;
        tick.rise = wrap & ~q.ph;
        tick.fall = wrap & q.ph;
        if (wrap) begin
            d.cnt = '0;
            d.ph  = ~q.ph;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/scan_bitmap.sv
module scan_bitmap #(
    parameter int COLS = 10,
    parameter int ROWS = 5,
    localparam int CW    = $clog2(COLS),
    localparam int RW    = $clog2(ROWS),
    localparam int DEPTH = COLS * ROWS,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] wcol,
    input  logic [RW-1:0] wrow,
    input  logic          wbit,
    input  logic [CW-1:0] rcol,
    input  logic [RW-1:0] rrow,
    output logic          rbit
);

    logic [DEPTH-1:0] mem_d, mem_q;
    logic [IW-1:0]    widx, ridx;
    logic             wok;

    always_comb begin
        widx  = IW'(wrow) * IW'(COLS) + IW'(wcol);
        ridx  = IW'(rrow) * IW'(COLS) + IW'(rcol);
        wok   = (int'(wcol) < COLS) && (int'(wrow) < ROWS);
        mem_d = mem_q;
        if (we && wok) mem_d[widx] = wbit;
        rbit  = mem_q[ridx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/sync_scanout.sv
module sync_scanout
    import scan_pkg::*;
#(
    parameter int COLS  = 10,
    parameter int ROWS  = 5,
    parameter int DIV_W = 8,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             scan_rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_col,
    input  logic [RW-1:0]    wr_row,
    input  logic             wr_bit,
    output logic             pix_out,
    output logic             pix_clk_out
);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic          pix;
        logic          gclk;
    } scan_t;

    scan_t d, q;
    tick_t tick;
    logic  sync_lvl, sync_rise;
    logic  grst_lvl, grst_fall, cnt_clear;
    logic  pix_take, rd_bit;
    logic  [CW-1:0] col_q;
    logic  [RW-1:0] row_q;

    scan_sync_edge #(.IDLE(1'b0), .RISE_EDGE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sync_in),
        .lvl_o(sync_lvl), .edge_o(sync_rise)
    );

    scan_sync_edge #(.IDLE(1'b1), .RISE_EDGE(1'b0)) u_grst (
        .clk(clk), .rst_n(rst_n), .async_in(scan_rst_n),
        .lvl_o(grst_lvl), .edge_o(grst_fall)
    );

    scan_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick)
    );

    scan_bitmap #(.COLS(COLS), .ROWS(ROWS)) u_bmp (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wcol(wr_col), .wrow(wr_row), .wbit(wr_bit),
        .rcol(q.col), .rrow(q.row), .rbit(rd_bit)
    );

    always_comb begin
        pix_take  = tick.rise & sync_lvl;
        cnt_clear = grst_fall | ~grst_lvl;
        d         = q;

        if (sync_rise)
            d.row = (q.row == RW'(ROWS - 1)) ? '0 : q.row + 1'b1;

        if (pix_take) begin
            d.col = (q.col == CW'(COLS - 1)) ? '0 : q.col + 1'b1;
            d.pix = rd_bit;
        end

        if (cnt_clear) begin
            d.col = '0;
            d.row = '0;
        end

        if (!sync_lvl)      d.gclk = 1'b0;
        else if (tick.rise) d.gclk = 1'b1;
        else if (tick.fall) d.gclk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign col_q       = q.col;
    assign row_q       = q.row;
    assign pix_out     = q.pix;
    assign pix_clk_out = q.gclk;

endmodule

// File: rtl/sync_scanout_chk.sv
module sync_scanout_chk #(
    parameter int COLS = 10,
    parameter int ROWS = 5,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_lvl,
    input logic          sync_rise,
    input logic          grst_fall,
    input logic          pix_take,
    input logic [CW-1:0] col_q,
    input logic [RW-1:0] row_q,
    input logic          pix_out,
    input logic          pix_clk_out
);

    a_r3_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_q) < ROWS);

    a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(col_q) < COLS);

    a_r3_row_step_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q != $past(row_q)) |-> $past(sync_rise || grst_fall) || row_q == '0);

    a_r4_col_step_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q != $past(col_q)) |-> $past(pix_take) || col_q == '0);

    a_r5_out_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_out != $past(pix_out)) |-> $past(pix_take));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        grst_fall |=> (col_q == '0 && row_q == '0));

    a_r7_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_lvl |=> !pix_clk_out);

    a_r7_clk_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk_out) |-> $past(pix_take));

endmodule

bind sync_scanout sync_scanout_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sync_lvl(sync_lvl), .sync_rise(sync_rise), .grst_fall(grst_fall),
    .pix_take(pix_take), .col_q(col_q), .row_q(row_q),
    .pix_out(pix_out), .pix_clk_out(pix_clk_out)
);

// File: tb/test_sync_scanout.sv
module test_sync_scanout;

    localparam int COLS  = 10;
    localparam int ROWS  = 5;
    localparam int DIV_W = 8;
    localparam int CW    = $clog2(COLS);
    localparam int RW    = $clog2(ROWS);

    typedef struct packed {
        logic [7:0]  div;
        logic [15:0] hi;
        logic        grst;
    } vec_t;

    // one line per entry: divider value, sync-high cycles, counter reset before
    localparam vec_t TABLE [12] = '{
        '{8'd1, 16'd30, 1'b0}, '{8'd2, 16'd40, 1'b0}, '{8'd0, 16'd26, 1'b0},
        '{8'd3, 16'd70, 1'b0}, '{8'd1, 16'd22, 1'b1}, '{8'd5, 16'd90, 1'b0},
        '{8'd1, 16'd44, 1'b0}, '{8'd0, 16'd18, 1'b0}, '{8'd2, 16'd50, 1'b1},
        '{8'd4, 16'd66, 1'b0}, '{8'd1, 16'd36, 1'b0}, '{8'd3, 16'd48, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_in = 1'b0;
    logic             scan_rst_n = 1'b1;
    logic [DIV_W-1:0] div_val = 8'd1;
    logic             wr_en = 1'b0;
    logic [CW-1:0]    wr_col = '0;
    logic [RW-1:0]    wr_row = '0;
    logic             wr_bit = 1'b0;
    logic             pix_out, pix_clk_out;

    sync_scanout #(.COLS(COLS), .ROWS(ROWS), .DIV_W(DIV_W)) i_sync_scanout (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .scan_rst_n(scan_rst_n),
        .div_val(div_val), .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row),
        .wr_bit(wr_bit), .pix_out(pix_out), .pix_clk_out(pix_clk_out)
    );

    always #10 clk = ~clk;

    bit bm   [COLS][ROWS];
    bit seen [COLS][ROWS];
    int ecol = 0, erow = 0;
    int nvec = 0, nerr = 0;
    int cyc = 0, low_cnt = 0, rises_low = 0;
    int line_rises = 0, last_rise = 0, period = 0;
    bit prev_clk = 1'b0, got_first = 1'b0, line_first = 1'b0, done = 1'b0;

    // pixel monitor: every rising pixel clock delivers the model's next pixel (R5, R4, R3)
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (pix_clk_out && !prev_clk) begin
                if (low_cnt >= 4) rises_low = rises_low + 1;
                nvec = nvec + 1;
                if (pix_out !== bm[ecol][erow]) begin
                    nerr = nerr + 1;
                    $display("FAIL R5 (address R4/R3) col %0d row %0d: got %0b expected %0b",
                             ecol, erow, pix_out, bm[ecol][erow]);
                end
                seen[ecol][erow] = 1'b1;
                if (!got_first) begin
                    line_first = pix_out;
                    got_first  = 1'b1;
                end
                if (line_rises > 0) period = cyc - last_rise;
                last_rise  = cyc;
                line_rises = line_rises + 1;
                ecol = (ecol == COLS - 1) ? 0 : ecol + 1;
            end
            prev_clk = pix_clk_out;
        end
        low_cnt = sync_in ? 0 : low_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec = nvec + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pat(input int c, input int r, input int s);
        return ((c * 3 + r * 7 + s) % 5) < 2;
    endfunction

    task automatic load_bitmap(input int s);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                wr_en  = 1'b1;
                wr_col = CW'(c);
                wr_row = RW'(r);
                wr_bit = pat(c, r, s);
                bm[c][r] = pat(c, r, s);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_line(input int div);
        @(negedge clk);
        div_val = DIV_W'(div);
        repeat (4) @(negedge clk);
        sync_in    = 1'b1;
        erow       = (erow + 1) % ROWS;
        got_first  = 1'b0;
        line_rises = 0;
    endtask

    task automatic end_line();
        sync_in = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_grst();
        @(negedge clk);
        scan_rst_n = 1'b0;
        ecol = 0;
        erow = 0;
        repeat (6) @(negedge clk);
        scan_rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr = nerr + 1;
            $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int exp_p, c, r;
        bit old;

        repeat (5) @(negedge clk);
        // R1: outputs idle during and after reset
        check(pix_out == 1'b0, "R1 pix_out in reset", int'(pix_out), 0);
        check(pix_clk_out == 1'b0, "R1 pix_clk_out in reset", int'(pix_clk_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pix_clk_out == 1'b0, "R1 pix_clk_out after reset", int'(pix_clk_out), 0);

        // R1: blank bitmap scans out zeros (monitor compares against zero model)
        start_line(1);
        repeat (24) @(negedge clk);
        end_line();

        // R2: sync latency through the synchronizer
        @(negedge clk);
        div_val = 8'd1;
        repeat (4) @(negedge clk);
        sync_in    = 1'b1;
        erow       = (erow + 1) % ROWS;
        got_first  = 1'b0;
        line_rises = 0;
        repeat (3) @(negedge clk);
        check(pix_clk_out == 1'b0, "R2 clock still off after third edge", int'(pix_clk_out), 0);
        repeat (2) @(negedge clk);
        check(line_rises >= 1, "R2 clock running by fifth edge", line_rises, 1);
        repeat (20) @(negedge clk);
        end_line();

        // R9: load a pattern while sync is low
        load_bitmap(0);

        // vector table walk
        for (int i = 0; i < 12; i++) begin
            if (TABLE[i].grst) pulse_grst();
            start_line(int'(TABLE[i].div));
            repeat (int'(TABLE[i].hi)) @(negedge clk);
            end_line();
            check(line_rises > 0, "R4 pixels advance while sync high", line_rises, 1);
            exp_p = (TABLE[i].div == 0) ? 2 : 2 * int'(TABLE[i].div);
            if (line_rises > 1)
                check(period == exp_p, (TABLE[i].div == 0) ? "R8 period for zero divide" :
                      "R7 pixel clock period", period, exp_p);
            if (TABLE[i].grst)
                // R6: after the counter reset the first pixel is column 0 of row 1
                check(line_first == bm[0][1], "R6 first pixel after counter reset",
                      int'(line_first), int'(bm[0][1]));
        end

        // R9: rewrite the bitmap, then scan it
        load_bitmap(3);
        for (int i = 0; i < 3; i++) begin
            start_line(2);
            repeat (50) @(negedge clk);
            end_line();
        end

        // R9: write at the same edge as the read of that location returns the old bit
        start_line(1);
        while (line_rises < 2) @(negedge clk);
        while (pix_clk_out) @(negedge clk);
        c = ecol;
        r = erow;
        old = bm[c][r];
        wr_en  = 1'b1;
        wr_col = CW'(c);
        wr_row = RW'(r);
        wr_bit = ~old;
        @(negedge clk);
        wr_en = 1'b0;
        check(pix_out == old, "R9 same-edge write shows old bit", int'(pix_out), int'(old));
        @(posedge clk);
        #1 bm[c][r] = ~old;
        repeat (20) @(negedge clk);
        end_line();

        // R10: sweep a full frame so every location of the default 10x5 map is read
        pulse_grst();
        for (int i = 0; i < ROWS + 1; i++) begin
            start_line(1);
            repeat (60) @(negedge clk);
            end_line();
        end
        begin
            int cnt = 0;
            for (int cc = 0; cc < COLS; cc++)
                for (int rr = 0; rr < ROWS; rr++)
                    if (seen[cc][rr]) cnt++;
            check(cnt == COLS * ROWS, "R10 all bitmap locations scanned", cnt, COLS * ROWS);
        end

        // R7: no pixel clock edge ever seen while sync was settled low
        check(rises_low == 0, "R7 clock held off while sync low", rises_low, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule